// File: doc/BRIEF.md
# Multi-Rate System Time Counter

This block keeps system time for an always-on domain. It counts cycles of its reference clock, holds the result in a 56-bit register, and drives that value, zero-extended to 64 bits, to every timer that consumes it. Software controls it through a small synchronous register port. Through that port software can start and stop counting, read or overwrite the count, arm a debug-halt freeze, and request one of several update rates.

The counter has a set of update modes. Mode m lets `4^m` reference cycles pass between updates and adds `4^m` at each update. The count therefore advances at the same average rate in every mode, and a slower mode toggles far fewer flops. A prescaler inside the block produces the update pulse. A requested mode change is applied only at an update boundary, so no partial step ever reaches the count. A read-only field reports the mode currently in effect.

Top module: `sys_time_counter`

## Requirements
- R1: The count is 56 bits wide and wraps modulo 2^56. Bits 63..56 of `count_o` and bits 31..24 of the high count word (address 2) always read as zero, and high-word write bits beyond the implemented width are discarded.
- R2: After reset the count is zero, the control word (address 0) reads zero, and mode 0 is in effect.
- R3: In mode 0, the count grows by exactly 1 on every cycle in which counting runs.
- R4: In mode m (m = 1, 2), the count grows by 4^m once every 4^m running cycles. A window that has not completed adds nothing.
- R5: While the enable bit (address 0, bit 0) is clear, the count holds its value.
- R6: When the halt-enable bit (address 0, bit 1) is set, an asserted `dbg_halt` freezes the count. When that bit is clear, `dbg_halt` has no effect.
- R7: The requested-mode field sits at address 0, bits 5..4. A write of a value of 3 or more (not a legal mode) leaves the field unchanged.
- R8: The mode in effect reads at address 0, bits 9..8. A new request replaces it only when an update window completes, or when counting is stopped and no window is in progress.
- R9: Address 1 reads and writes count bits 31..0, and address 2 reads and writes the bits above them. Writing either word restarts the update window, and that write takes priority over an update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for counting and for the register port |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_halt | input | 1 | Debug halt request; takes effect only when halt-enable is set |
| reg_addr | input | 2 | Register select: 0 control, 1 count low, 2 count high |
| reg_wr | input | 1 | Write strobe, applied at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| count_o | output | 64 | Current count, zero-extended, shared with timer consumers |

## Verification
A table of runs sets a mode, a start value, halt settings and a run length, then compares the final count with the stepped amount computed in the bench. Run lengths that are exact multiples of the mode period and run lengths that stop mid-window tell a correct prescaler from one that adds steps early or in pieces. Runs that pair halt with halt-enable set and clear tell a gated halt from an ungated one, and start values just below 2^56 check the wrap. A directed sequence requests a new mode in the middle of a window and shows that the old step is finished before the new rate applies.

// File: rtl/sctr_pkg.sv
package sctr_pkg;
  localparam logic [1:0] RA_CTRL   = 2'd0;
  localparam logic [1:0] RA_CNT_LO = 2'd1;
  localparam logic [1:0] RA_CNT_HI = 2'd2;

  localparam int CTL_EN_BIT     = 0;
  localparam int CTL_HALTEN_BIT = 1;
  localparam int CTL_REQ_LSB    = 4;
  localparam int CTL_ACT_LSB    = 8;

  // Reference cycles per update (and step size) for a given mode.
  function automatic int unsigned mode_period(input int unsigned mode,
                                              input int unsigned ratio_log);
    return 32'd1 << (ratio_log * mode);
  endfunction
endpackage

// File: rtl/sctr_ctrl.sv
module sctr_ctrl #(
  parameter int NUM_MODES = 3,
  parameter int MODE_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_en_bit,
  input  logic              wr_halten_bit,
  input  logic [MODE_W-1:0] wr_mode,
  output logic              en,
  output logic              halt_en,
  output logic [MODE_W-1:0] req_mode
);
  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return 32'(m) < NUM_MODES;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      halt_en  <= 1'b0;
      req_mode <= '0;
    end else if (wr_ctrl) begin
      en      <= wr_en_bit;
      halt_en <= wr_halten_bit;
      if (mode_legal(wr_mode)) req_mode <= wr_mode;
    end
  end
endmodule

// File: rtl/sctr_prescaler.sv
module sctr_prescaler #(
  parameter int NUM_MODES = 3,
  parameter int MODE_W    = 2,
  parameter int RATIO_LOG = 2,
  parameter int PC_W      = RATIO_LOG * (NUM_MODES - 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              restart,
  input  logic [MODE_W-1:0] req_mode,
  output logic              tick,
  output logic              window_open,
  output logic [MODE_W-1:0] active_mode,
  output logic [PC_W-1:0]   step
);
  logic [PC_W-1:0] period_tbl [NUM_MODES];
  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] last_pc;
  logic            adopt;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_period
    assign period_tbl[g] = PC_W'(sctr_pkg::mode_period(g, RATIO_LOG));
  end

  assign step        = period_tbl[active_mode];
  assign last_pc     = step - PC_W'(1);
  assign tick        = run && (pc == last_pc);
  assign window_open = (pc != '0);
  // A new mode is taken only at an update boundary.
  assign adopt       = tick || (!run && !window_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc          <= '0;
      active_mode <= '0;
    end else begin
      if (adopt) active_mode <= req_mode;
      if (restart || tick) pc <= '0;
      else if (run)        pc <= pc + PC_W'(1);
    end
  end
endmodule

// File: rtl/sctr_counter.sv
module sctr_counter #(
  parameter int CNT_W  = 56,
  parameter int STEP_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [31:0]       wdata,
  output logic [CNT_W-1:0]  count
);
  localparam int HI_W = CNT_W - 32;

  function automatic logic [CNT_W-1:0] advance(input logic [CNT_W-1:0] c,
                                               input logic [STEP_W-1:0] s);
    return c + CNT_W'(s);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        count <= '0;
    else if (wr_lo)    count[31:0]       <= wdata;
    else if (wr_hi)    count[CNT_W-1:32] <= wdata[HI_W-1:0];
    else if (tick)     count <= advance(count, step);
  end
endmodule

// File: rtl/sys_time_counter.sv
module sys_time_counter #(
  parameter int CNT_W     = 56,
  parameter int NUM_MODES = 3,
  parameter int RATIO_LOG = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dbg_halt,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic [63:0] count_o
);
  import sctr_pkg::*;

  localparam int MODE_W = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1;
  localparam int PC_W   = RATIO_LOG * (NUM_MODES - 1) + 1;

  logic              en, halt_en, run, tick, window_open;
  logic              wr_ctrl, wr_lo, wr_hi, cnt_wr;
  logic [MODE_W-1:0] req_mode, active_mode;
  logic [PC_W-1:0]   step;
  logic [CNT_W-1:0]  count;
  logic [31:0]       ctrl_rd;

  assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
  assign wr_lo   = reg_wr && (reg_addr == RA_CNT_LO);
  assign wr_hi   = reg_wr && (reg_addr == RA_CNT_HI);
  assign cnt_wr  = wr_lo || wr_hi;
  assign run     = en && !(halt_en && dbg_halt);

  sctr_ctrl #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_ctrl       (wr_ctrl),
    .wr_en_bit     (reg_wdata[CTL_EN_BIT]),
    .wr_halten_bit (reg_wdata[CTL_HALTEN_BIT]),
    .wr_mode       (reg_wdata[CTL_REQ_LSB +: MODE_W]),
    .en            (en),
    .halt_en       (halt_en),
    .req_mode      (req_mode)
  );

  sctr_prescaler #(.NUM_MODES(NUM_MODES), .MODE_W(MODE_W),
                   .RATIO_LOG(RATIO_LOG), .PC_W(PC_W)) u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .restart     (cnt_wr),
    .req_mode    (req_mode),
    .tick        (tick),
    .window_open (window_open),
    .active_mode (active_mode),
    .step        (step)
  );

  sctr_counter #(.CNT_W(CNT_W), .STEP_W(PC_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .step  (step),
    .wr_lo (wr_lo),
    .wr_hi (wr_hi),
    .wdata (reg_wdata),
    .count (count)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTL_EN_BIT]                 = en;
    ctrl_rd[CTL_HALTEN_BIT]             = halt_en;
    ctrl_rd[CTL_REQ_LSB +: MODE_W]      = req_mode;
    ctrl_rd[CTL_ACT_LSB +: MODE_W]      = active_mode;
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = ctrl_rd;
      RA_CNT_LO: reg_rdata = count[31:0];
      RA_CNT_HI: reg_rdata = 32'(count[CNT_W-1:32]);
      default:   reg_rdata = '0;
    endcase
  end

  assign count_o = 64'(count);
endmodule

// File: rtl/sctr_checker.sv
module sctr_checker #(
  parameter int CNT_W     = 56,
  parameter int NUM_MODES = 3,
  parameter int MODE_W    = 2,
  parameter int STEP_W    = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [63:0]       count_o,
  input logic              tick,
  input logic              run,
  input logic              en,
  input logic              halt_en,
  input logic              dbg_halt,
  input logic              cnt_wr,
  input logic              window_open,
  input logic [STEP_W-1:0] step,
  input logic [MODE_W-1:0] active_mode
);
  localparam logic [63:0] CNT_MASK = (CNT_W >= 64) ? '1 : ((64'd1 << CNT_W) - 64'd1);

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o & ~CNT_MASK) == 64'd0);  // R1
  AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr) |=> count_o == (($past(count_o) + 64'($past(step))) & CNT_MASK));  // R4
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> $stable(count_o));  // R5
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_en && dbg_halt && !cnt_wr) |=> $stable(count_o));  // R6
  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);  // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    32'(active_mode) < NUM_MODES);  // R7
  AST_MODE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && (run || window_open)) |=> $stable(active_mode));  // R8
endmodule

bind sys_time_counter sctr_checker #(
  .CNT_W(CNT_W), .NUM_MODES(NUM_MODES), .MODE_W(MODE_W), .STEP_W(PC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .count_o     (count_o),
  .tick        (tick),
  .run         (run),
  .en          (en),
  .halt_en     (halt_en),
  .dbg_halt    (dbg_halt),
  .cnt_wr      (cnt_wr),
  .window_open (window_open),
  .step        (step),
  .active_mode (active_mode)
);

// File: tb/sys_time_counter_tb.sv
module sys_time_counter_tb;
  localparam logic [63:0] MASK56 = (64'd1 << 56) - 64'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_halt = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] count_o;

  int n_chk = 0;
  int n_fail = 0;

  sys_time_counter u_dut (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  mode;
    logic        hen;
    logic        halt;
    logic [63:0] start;
    logic [31:0] ncyc;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{2'd0, 1'b0, 1'b0, 64'd0,                   32'd10},  // R3
    '{2'd1, 1'b0, 1'b0, 64'd100,                 32'd9},   // R4 partial tail
    '{2'd2, 1'b0, 1'b0, 64'd5,                   32'd40},  // R4
    '{2'd2, 1'b0, 1'b0, 64'd7,                   32'd15},  // R4 incomplete window
    '{2'd0, 1'b1, 1'b1, 64'd50,                  32'd7},   // R6 frozen
    '{2'd0, 1'b0, 1'b1, 64'd50,                  32'd7},   // R6 ignored
    '{2'd1, 1'b1, 1'b0, 64'h1_2345_6789,         32'd8},   // R6 armed, no halt
    '{2'd0, 1'b0, 1'b0, 64'h00FF_FFFF_FFFF_FFFE, 32'd5},   // R1 wrap
    '{2'd1, 1'b0, 1'b0, 64'h00FF_FFFF_FFFF_FFFC, 32'd4}    // R1 wrap by step
  };

  function automatic logic [63:0] exp_delta(input logic [1:0] m, input logic hen,
                                            input logic halt, input int n);
    int p;
    if (hen && halt) return 64'd0;
    p = 1 << (2 * int'(m));
    return 64'((n / p) * p);
  endfunction

  function automatic logic [31:0] ctrl_word(input logic en, input logic hen,
                                            input logic [1:0] m);
    return {26'd0, m, 2'b00, hen, en};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_count(output logic [63:0] c);
    logic [31:0] lo, hi;
    rd(2'd1, lo);
    rd(2'd2, hi);
    c = {hi, lo};
  endtask

  task automatic run_cycles(input logic hen, input logic [1:0] m, input int n);
    wr(2'd0, ctrl_word(1'b1, hen, m));
    repeat (n - 1) @(posedge clk);
    wr(2'd0, ctrl_word(1'b0, hen, m));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    n_fail++;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] c, exp;

    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R2: reset state
    rd(2'd0, d); check("R2 ctrl", 64'(d), 64'd0);
    rd_count(c); check("R2 count", c, 64'd0);
    @(negedge clk); check("R2 count_o", count_o, 64'd0);

    // Vector table
    for (int i = 0; i < 9; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk) dbg_halt = v.halt;
      wr(2'd0, ctrl_word(1'b0, v.hen, v.mode));
      wr(2'd1, v.start[31:0]);
      wr(2'd2, v.start[63:32]);
      repeat (2) @(posedge clk);
      rd_count(c); check("R9 count write readback", c, v.start);
      rd(2'd0, d); check("R8 mode in effect", 64'(d[9:8]), 64'(v.mode));
      run_cycles(v.hen, v.mode, int'(v.ncyc));
      exp = (v.start + exp_delta(v.mode, v.hen, v.halt, int'(v.ncyc))) & MASK56;
      rd_count(c); check("R3/R4/R6 count after run", c, exp);
      @(negedge clk); check("R1 count_o zero-extended", count_o, exp);
    end
    @(negedge clk) dbg_halt = 1'b0;

    // R1: high-word bits above width discarded
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); check("R1 high word", 64'(d), 64'h00FF_FFFF);

    // R8: mode change requested mid-window
    wr(2'd0, ctrl_word(1'b0, 1'b0, 2'd1));
    wr(2'd1, 32'd0);
    wr(2'd2, 32'd0);
    repeat (2) @(posedge clk);
    run_cycles(1'b0, 2'd1, 6);
    rd_count(c); check("R4 mode1 six cycles", c, 64'd4);
    wr(2'd0, ctrl_word(1'b0, 1'b0, 2'd0));
    rd(2'd0, d); check("R8 old mode kept mid-window", 64'(d[9:8]), 64'd1);
    check("R7 request stored", 64'(d[5:4]), 64'd0);
    run_cycles(1'b0, 2'd0, 2);
    rd_count(c); check("R8 window finished at old step", c, 64'd8);
    rd(2'd0, d); check("R8 new mode after boundary", 64'(d[9:8]), 64'd0);
    run_cycles(1'b0, 2'd0, 3);
    rd_count(c); check("R3 mode0 after change", c, 64'd11);

    // R5: disabled count holds
    repeat (10) @(posedge clk);
    rd_count(c); check("R5 hold while disabled", c, 64'd11);

    // R7: illegal mode request ignored
    wr(2'd0, ctrl_word(1'b0, 1'b0, 2'd3));
    rd(2'd0, d); check("R7 illegal request dropped", 64'(d), 64'd0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule